// File: doc/BRIEF.md
# Single-Fault Injection Run Controller

This block runs one fault-injection experiment on a small state machine. It holds two identical copies of that state machine. Both copies are cleared together and then fed the same stimulus word on the same cycle. The words are read one after another from an external vector store. When the programmed injection cycle is reached, exactly one state bit of the second copy is inverted. Both copies then keep running, and the block watches how the two copies drift apart.

A run is configured with five values: the injection cycle, the bit location, the number of vectors, a test mode and a halt option. The run is launched with a start pulse. The test mode sets how the run is classified. Output mode stops the run at the first output disagreement. Latent mode separates faults that reach the outputs from faults that stay hidden in the state. Damage mode only asks whether the state still differs when the run ends.

With the halt option set, the run parks just before the flip. From there a host can examine the copies, perform the flip, single-step one cycle at a time, or let the run continue. The block also gives the bitwise difference of the two state vectors and the number of differing bits.

Top module: `seuinj_top`

## Requirements
- R1: After reset, stsDone, stsHold, stsInjected and stsMisSeen are 0, stsClass is 0, vecAddr is 0 and both state vectors are 0.
- R2: cmdStart is taken only when the controller is idle or finished. Taking it latches the configuration, clears the status fields and starts a run. A start pulse at any other time changes nothing.
- R3: Both copies are cleared at the start of every run and then receive the same vector on the same edge. Until the flip, refState equals faultState.
- R4: Before the flip, exactly min(T, N) vectors are applied, read from addresses 0, 1, 2 … in order. vecAddr always equals the number of vectors applied so far in the run.
- R5: The copy under test is a state vector {hold, acc}. acc is bits DW-1..0 and holds a running sum of the vector's data field (bits DW-1..0). acc drives the outputs. hold is bits 2*DW-1..DW and loads the data field whenever vector bit DW is 1. On one edge with no vector applied, the flip inverts state bit L of the faulty copy only.
- R6: diffState is refState XOR faultState, and diffCount is the number of ones in it.
- R7: Mode codes are 0 damage, 1 output, 2 latent, and 3 behaves as damage. Class codes are 0 no effect, 1 output error, 2 latent, 3 damage. In output mode the run ends with class 1 on the first observed cycle in which the outputs differ. If the vectors run out without such a cycle, the class is 0.
- R8: In latent mode the run always uses all N vectors. The class is 1 if the outputs ever differed. Otherwise it is 2 if the states differ at the end, and 0 if they do not.
- R9: In damage mode the run uses all N vectors. The class is 3 if the states differ at the end, otherwise 0.
- R10: stsMisSeen rises, and stsFirstMis captures the value of vecAddr, on the first observed cycle after the flip in which the two output words differ.
- R11: With cfgHalt set, the run parks (stsHold=1) with no flip done and both copies frozen. In the parked state, cmdStep first performs the flip; each later cmdStep applies exactly one vector and makes one observation.
- R12: In the parked state, cmdResume continues the run. It first performs the flip if that has not happened yet.
- R13: If T is N or more, the flip is placed after the last vector, and the run ends on the following observed cycle.
- R14: stsDone stays high with all status fields unchanged until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | Launch a run |
| cmdStep | input | 1 | In the parked state: flip, or advance one cycle |
| cmdResume | input | 1 | In the parked state: continue freely |
| cfgInjCycle | input | CW | Injection cycle T |
| cfgLoc | input | log2(2*DW) | Bit location L of the flip |
| cfgMode | input | 2 | Test mode |
| cfgHalt | input | 1 | Park at the injection point |
| cfgNumVec | input | CW | Number of vectors N |
| vecAddr | output | CW | Vector store read address |
| vecData | input | DW+1 | Vector word at vecAddr |
| stsDone | output | 1 | Run finished |
| stsHold | output | 1 | Parked |
| stsInjected | output | 1 | Flip performed in this run |
| stsClass | output | 2 | Effect class |
| stsMisSeen | output | 1 | Outputs have differed |
| stsFirstMis | output | CW | Cycle of the first output difference |
| refState | output | 2*DW | Reference copy state |
| faultState | output | 2*DW | Faulty copy state |
| diffState | output | 2*DW | Bitwise state difference |
| diffCount | output | log2(2*DW+1) | Number of differing bits |
| refOut | output | DW | Reference copy output |
| faultOut | output | DW | Faulty copy output |

## Verification
The property checks run on every cycle. They check that the copies stay in lockstep until the flip and that the flip changes exactly one bit. They also check that diffCount matches diffState, that the parked state freezes both copies, and that each step advances the address by exactly one. Two more checks cover the address, which only counts up or clears, and the finished flag, which stays high until a start pulse.

The effect classes for each mode, the recorded first-mismatch cycle, a start pulse ignored mid-run and while parked, and an injection cycle past the end of the stream only show up in the bench scenarios. In each scenario the behavioural model and a hand-worked expected class must both agree with the block.

// File: rtl/seuinj_pkg.sv
package seuinj_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_RUN_TO_T,
    ST_INJECT,
    ST_OBSERVE,
    ST_HOLD,
    ST_DONE
  } ctlState_e;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_OUTPUT = 2'd1,
    CLS_LATENT = 2'd2,
    CLS_DAMAGE = 2'd3
  } effect_e;

  localparam logic [1:0] MODE_DAMAGE = 2'd0;
  localparam logic [1:0] MODE_OUTPUT = 2'd1;
  localparam logic [1:0] MODE_LATENT = 2'd2;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;    // latch config, clear counters and status
    logic mutRst;  // clear both copies
    logic adv;     // apply current vector to both copies
    logic flip;    // invert the selected bit in the faulty copy
    logic obs;     // compare outputs this cycle
    logic finish;  // latch the effect class
  } dpStrobe_t;

endpackage

// File: rtl/seuinj_mut.sv
module seuinj_mut #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncClr,
  input  logic              adv,
  input  logic              flip,
  input  logic [2*DW-1:0]   flipMask,
  input  logic [DW:0]       vec,
  output logic [2*DW-1:0]   stateQ,
  output logic [DW-1:0]     outQ
);

  logic [DW-1:0] accQ;
  logic [DW-1:0] holdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= '0;
      holdQ <= '0;
    end else if (syncClr) begin
      accQ  <= '0;
      holdQ <= '0;
    end else if (flip) begin
      accQ  <= accQ ^ flipMask[DW-1:0];
      holdQ <= holdQ ^ flipMask[2*DW-1:DW];
    end else if (adv) begin
      accQ <= accQ + vec[DW-1:0];
      if (vec[DW]) holdQ <= vec[DW-1:0];
    end
  end

  assign stateQ = {holdQ, accQ};
  assign outQ   = accQ;

endmodule

// File: rtl/seuinj_dp.sv
module seuinj_dp
  import seuinj_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   stb,
  input  logic [CW-1:0]               cfgInjCycle,
  input  logic [$clog2(2*DW)-1:0]     cfgLoc,
  input  logic [1:0]                  cfgMode,
  input  logic                        cfgHalt,
  input  logic [CW-1:0]               cfgNumVec,
  input  logic [DW:0]                 vecData,
  output logic [CW-1:0]               vecAddr,
  output logic                        atT,
  output logic                        atEnd,
  output logic                        outMis,
  output logic [1:0]                  modeQ,
  output logic                        haltQ,
  output logic [1:0]                  clsOut,
  output logic                        misSeenOut,
  output logic [CW-1:0]               firstMisOut,
  output logic [2*DW-1:0]             refState,
  output logic [2*DW-1:0]             faultState,
  output logic [2*DW-1:0]             diffState,
  output logic [$clog2(2*DW+1)-1:0]   diffCount,
  output logic [DW-1:0]               refOut,
  output logic [DW-1:0]               faultOut
);

  localparam int SW  = 2 * DW;
  localparam int LW  = $clog2(SW);
  localparam int DCW = $clog2(SW + 1);
  localparam int NCOPY = 2;

  logic [CW-1:0] tQ;
  logic [CW-1:0] nQ;
  logic [LW-1:0] locQ;
  logic [CW-1:0] cntQ;
  logic          misSeenQ;
  logic [CW-1:0] firstMisQ;
  effect_e       clsQ;
  effect_e       clsNxt;
  logic [SW-1:0] flipMask;
  logic [SW-1:0] stArr  [NCOPY];
  logic [DW-1:0] outArr [NCOPY];
  logic          stateDiff;
  logic          misAny;

  // one-hot flip mask at the latched location
  for (genvar b = 0; b < SW; b++) begin : g_mask
    assign flipMask[b] = (locQ == LW'(b));
  end

  // copy 0 is the reference, copy 1 takes the flip
  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    seuinj_mut #(.DW(DW)) i_mut (
      .clk     (clk),
      .rstN    (rstN),
      .syncClr (stb.mutRst),
      .adv     (stb.adv),
      .flip    (stb.flip && (g == 1)),
      .flipMask(flipMask),
      .vec     (vecData),
      .stateQ  (stArr[g]),
      .outQ    (outArr[g])
    );
  end

  assign refState   = stArr[0];
  assign faultState = stArr[1];
  assign refOut     = outArr[0];
  assign faultOut   = outArr[1];
  assign diffState  = stArr[0] ^ stArr[1];
  assign stateDiff  = |diffState;
  assign outMis     = (outArr[0] != outArr[1]);
  assign misAny     = misSeenQ | outMis;

  always_comb begin
    diffCount = '0;
    for (int i = 0; i < SW; i++) diffCount = diffCount + DCW'(diffState[i]);
  end

  always_comb begin
    case (modeQ)
      MODE_OUTPUT: clsNxt = misAny ? CLS_OUTPUT : CLS_NONE;
      MODE_LATENT: clsNxt = misAny ? CLS_OUTPUT : (stateDiff ? CLS_LATENT : CLS_NONE);
      default:     clsNxt = stateDiff ? CLS_DAMAGE : CLS_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tQ        <= '0;
      nQ        <= '0;
      locQ      <= '0;
      modeQ     <= MODE_DAMAGE;
      haltQ     <= 1'b0;
      cntQ      <= '0;
      misSeenQ  <= 1'b0;
      firstMisQ <= '0;
      clsQ      <= CLS_NONE;
    end else if (stb.load) begin
      tQ        <= cfgInjCycle;
      nQ        <= cfgNumVec;
      locQ      <= cfgLoc;
      modeQ     <= cfgMode;
      haltQ     <= cfgHalt;
      cntQ      <= '0;
      misSeenQ  <= 1'b0;
      firstMisQ <= '0;
      clsQ      <= CLS_NONE;
    end else begin
      if (stb.adv) cntQ <= cntQ + CW'(1);
      if (stb.obs && outMis && !misSeenQ) begin
        misSeenQ  <= 1'b1;
        firstMisQ <= cntQ;
      end
      if (stb.finish) clsQ <= clsNxt;
    end
  end

  assign vecAddr     = cntQ;
  assign atEnd       = (cntQ == nQ);
  assign atT         = (cntQ == tQ) || atEnd;
  assign clsOut      = clsQ;
  assign misSeenOut  = misSeenQ;
  assign firstMisOut = firstMisQ;

endmodule

// File: rtl/seuinj_ctl.sv
module seuinj_ctl
  import seuinj_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdStart,
  input  logic      cmdStep,
  input  logic      cmdResume,
  input  logic      atT,
  input  logic      atEnd,
  input  logic      outMis,
  input  logic [1:0] modeQ,
  input  logic      haltQ,
  output dpStrobe_t stb,
  output logic      injected,
  output logic      hold,
  output logic      done
);

  ctlState_e stQ, stNxt;
  logic      injQ, injNxt;
  logic      stopNow;

  // an observed cycle ends the run on an output hit in output mode or at stream end
  assign stopNow = (outMis && (modeQ == MODE_OUTPUT)) || atEnd;

  always_comb begin
    stb    = '0;
    stNxt  = stQ;
    injNxt = injQ;
    case (stQ)
      ST_IDLE, ST_DONE: begin
        if (cmdStart) begin
          stb.load = 1'b1;
          stNxt    = ST_RESET;
        end
      end
      ST_RESET: begin
        stb.mutRst = 1'b1;
        injNxt     = 1'b0;
        stNxt      = ST_RUN_TO_T;
      end
      ST_RUN_TO_T: begin
        if (atT) stNxt = haltQ ? ST_HOLD : ST_INJECT;
        else     stb.adv = 1'b1;
      end
      ST_INJECT: begin
        stb.flip = 1'b1;
        injNxt   = 1'b1;
        stNxt    = ST_OBSERVE;
      end
      ST_OBSERVE: begin
        stb.obs = 1'b1;
        if (stopNow) begin
          stb.finish = 1'b1;
          stNxt      = ST_DONE;
        end else begin
          stb.adv = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cmdStep) begin
          if (!injQ) begin
            stb.flip = 1'b1;
            injNxt   = 1'b1;
          end else begin
            stb.obs = 1'b1;
            if (stopNow) begin
              stb.finish = 1'b1;
              stNxt      = ST_DONE;
            end else begin
              stb.adv = 1'b1;
            end
          end
        end else if (cmdResume) begin
          stNxt = injQ ? ST_OBSERVE : ST_INJECT;
        end
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ  <= ST_IDLE;
      injQ <= 1'b0;
    end else begin
      stQ  <= stNxt;
      injQ <= injNxt;
    end
  end

  assign injected = injQ;
  assign hold     = (stQ == ST_HOLD);
  assign done     = (stQ == ST_DONE);

endmodule

// File: rtl/seuinj_top.sv
module seuinj_top
  import seuinj_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdStart,
  input  logic                        cmdStep,
  input  logic                        cmdResume,
  input  logic [CW-1:0]               cfgInjCycle,
  input  logic [$clog2(2*DW)-1:0]     cfgLoc,
  input  logic [1:0]                  cfgMode,
  input  logic                        cfgHalt,
  input  logic [CW-1:0]               cfgNumVec,
  output logic [CW-1:0]               vecAddr,
  input  logic [DW:0]                 vecData,
  output logic                        stsDone,
  output logic                        stsHold,
  output logic                        stsInjected,
  output logic [1:0]                  stsClass,
  output logic                        stsMisSeen,
  output logic [CW-1:0]               stsFirstMis,
  output logic [2*DW-1:0]             refState,
  output logic [2*DW-1:0]             faultState,
  output logic [2*DW-1:0]             diffState,
  output logic [$clog2(2*DW+1)-1:0]   diffCount,
  output logic [DW-1:0]               refOut,
  output logic [DW-1:0]               faultOut
);

  dpStrobe_t  stb;
  logic       atT;
  logic       atEnd;
  logic       outMis;
  logic [1:0] modeQ;
  logic       haltQ;

  seuinj_ctl i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStart (cmdStart),
    .cmdStep  (cmdStep),
    .cmdResume(cmdResume),
    .atT      (atT),
    .atEnd    (atEnd),
    .outMis   (outMis),
    .modeQ    (modeQ),
    .haltQ    (haltQ),
    .stb      (stb),
    .injected (stsInjected),
    .hold     (stsHold),
    .done     (stsDone)
  );

  seuinj_dp #(.DW(DW), .CW(CW)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgInjCycle(cfgInjCycle),
    .cfgLoc     (cfgLoc),
    .cfgMode    (cfgMode),
    .cfgHalt    (cfgHalt),
    .cfgNumVec  (cfgNumVec),
    .vecData    (vecData),
    .vecAddr    (vecAddr),
    .atT        (atT),
    .atEnd      (atEnd),
    .outMis     (outMis),
    .modeQ      (modeQ),
    .haltQ      (haltQ),
    .clsOut     (stsClass),
    .misSeenOut (stsMisSeen),
    .firstMisOut(stsFirstMis),
    .refState   (refState),
    .faultState (faultState),
    .diffState  (diffState),
    .diffCount  (diffCount),
    .refOut     (refOut),
    .faultOut   (faultOut)
  );

endmodule

// File: rtl/seuinj_chk.sv
module seuinj_chk #(
  parameter int DW = 8,
  parameter int CW = 10
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        cmdStart,
  input logic                        cmdStep,
  input logic [CW-1:0]               vecAddr,
  input logic                        stsDone,
  input logic                        stsHold,
  input logic                        stsInjected,
  input logic [1:0]                  stsClass,
  input logic                        stsMisSeen,
  input logic [2*DW-1:0]             refState,
  input logic [2*DW-1:0]             faultState,
  input logic [2*DW-1:0]             diffState,
  input logic [$clog2(2*DW+1)-1:0]   diffCount
);

  a_r3_lockstep: assert property (@(posedge clk) disable iff (!rstN)
    !stsInjected |-> (refState == faultState));

  a_r5_single_flip: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsInjected) |-> ($countones(refState ^ faultState) == 1));

  a_r6_popcount: assert property (@(posedge clk) disable iff (!rstN)
    diffCount == $countones(diffState));

  a_r11_hold_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (stsHold && !cmdStep) |=> ($stable(refState) && $stable(faultState)));

  a_r11_one_step: assert property (@(posedge clk) disable iff (!rstN)
    (stsHold && cmdStep && stsInjected) |=>
      ((vecAddr == $past(vecAddr) + CW'(1)) || stsDone));

  a_r4_addr_seq: assert property (@(posedge clk) disable iff (!rstN)
    (vecAddr != $past(vecAddr)) |-> ((vecAddr == $past(vecAddr) + CW'(1)) || (vecAddr == '0)));

  a_r14_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stsDone && !cmdStart) |=> (stsDone && $stable(stsClass)));

  a_r7_out_err_seen: assert property (@(posedge clk) disable iff (!rstN)
    (stsDone && stsClass == 2'd1) |-> stsMisSeen);

endmodule

bind seuinj_top seuinj_chk #(.DW(DW), .CW(CW)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdStart   (cmdStart),
  .cmdStep    (cmdStep),
  .vecAddr    (vecAddr),
  .stsDone    (stsDone),
  .stsHold    (stsHold),
  .stsInjected(stsInjected),
  .stsClass   (stsClass),
  .stsMisSeen (stsMisSeen),
  .refState   (refState),
  .faultState (faultState),
  .diffState  (diffState),
  .diffCount  (diffCount)
);

// File: tb/test_seuinj_top.sv
`timescale 1ns/1ps
module test_seuinj_top;

  localparam int DW = 8;
  localparam int CW = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0, cmdStep = 1'b0, cmdResume = 1'b0;
  logic [CW-1:0] cfgInjCycle = '0, cfgNumVec = '0;
  logic [3:0]  cfgLoc = '0;
  logic [1:0]  cfgMode = '0;
  logic        cfgHalt = 1'b0;
  logic [CW-1:0] vecAddr;
  logic [DW:0] vecData;
  logic        stsDone, stsHold, stsInjected, stsMisSeen;
  logic [1:0]  stsClass;
  logic [CW-1:0] stsFirstMis;
  logic [15:0] refState, faultState, diffState;
  logic [4:0]  diffCount;
  logic [7:0]  refOut, faultOut;

  logic [8:0] vmem [64];
  int nChk = 0, nBad = 0;

  // behavioural model state
  int mPh = 0, mCnt = 0, mT = 0, mN = 0, mL = 0, mMode = 0, mFirst = 0, mCls = 0;
  bit mHalt = 0, mInj = 0, mMis = 0;
  logic [7:0] mRa = 0, mRb = 0, mFa = 0, mFb = 0;

  always #2 clk = ~clk;

  assign vecData = vmem[vecAddr[5:0]];

  seuinj_top #(.DW(DW), .CW(CW)) i_seuinj_top (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdStep(cmdStep), .cmdResume(cmdResume),
    .cfgInjCycle(cfgInjCycle), .cfgLoc(cfgLoc), .cfgMode(cfgMode), .cfgHalt(cfgHalt),
    .cfgNumVec(cfgNumVec), .vecAddr(vecAddr), .vecData(vecData), .stsDone(stsDone),
    .stsHold(stsHold), .stsInjected(stsInjected), .stsClass(stsClass), .stsMisSeen(stsMisSeen),
    .stsFirstMis(stsFirstMis), .refState(refState), .faultState(faultState),
    .diffState(diffState), .diffCount(diffCount), .refOut(refOut), .faultOut(faultOut));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic mAdv();
    logic [8:0] v;
    v = vmem[mCnt[5:0]];
    mRa = mRa + v[7:0];
    mFa = mFa + v[7:0];
    if (v[8]) begin mRb = v[7:0]; mFb = v[7:0]; end
    mCnt++;
  endtask

  task automatic mFlip();
    if (mL < 8) mFa = mFa ^ (8'd1 << mL);
    else        mFb = mFb ^ (8'd1 << (mL - 8));
    mInj = 1;
  endtask

  task automatic mObserve();
    bit misNow, sd;
    misNow = (mRa != mFa);
    if (misNow && !mMis) begin mMis = 1; mFirst = mCnt; end
    if ((misNow && mMode == 1) || mCnt == mN) begin
      sd = ({mRb, mRa} != {mFb, mFa});
      if (mMode == 1)      mCls = mMis ? 1 : 0;
      else if (mMode == 2) mCls = mMis ? 1 : (sd ? 2 : 0);
      else                 mCls = sd ? 3 : 0;
      mPh = 6;
    end else begin
      mAdv();
    end
  endtask

  task automatic mStep();
    if (!rstN) begin
      mPh = 0; mCnt = 0; mT = 0; mN = 0; mL = 0; mMode = 0; mFirst = 0; mCls = 0;
      mHalt = 0; mInj = 0; mMis = 0; mRa = 0; mRb = 0; mFa = 0; mFb = 0;
      return;
    end
    case (mPh)
      0, 6: if (cmdStart) begin
        mT = int'(cfgInjCycle); mN = int'(cfgNumVec); mL = int'(cfgLoc);
        mMode = int'(cfgMode); mHalt = cfgHalt;
        mCnt = 0; mMis = 0; mFirst = 0; mCls = 0; mPh = 1;
      end
      1: begin mRa = 0; mRb = 0; mFa = 0; mFb = 0; mInj = 0; mPh = 2; end
      2: if (mCnt == mT || mCnt == mN) mPh = mHalt ? 5 : 3; else mAdv();
      3: begin mFlip(); mPh = 4; end
      4: mObserve();
      5: if (cmdStep) begin
           if (!mInj) mFlip(); else mObserve();
         end else if (cmdResume) mPh = mInj ? 4 : 3;
      default: mPh = 0;
    endcase
  endtask

  task automatic cmpAll();
    chk("R14", 32'(stsDone), 32'(mPh == 6), "done");
    chk("R9", 32'(stsClass), 32'(mCls), "class");
    chk("R4", 32'(vecAddr), 32'(mCnt), "vecAddr");
    chk("R3", 32'(refState), 32'({mRb, mRa}), "refState");
    chk("R5", 32'(faultState), 32'({mFb, mFa}), "faultState");
    chk("R11", 32'(stsHold), 32'(mPh == 5), "hold");
    chk("R5", 32'(stsInjected), 32'(mInj), "injected");
    chk("R10", 32'(stsMisSeen), 32'(mMis), "misSeen");
    chk("R10", 32'(stsFirstMis), 32'(mFirst), "firstMis");
  endtask

  task automatic tick();
    @(posedge clk);
    mStep();
    @(negedge clk);
    cmpAll();
  endtask

  task automatic startRun(int t, int l, int mode, bit halt, int n);
    cfgInjCycle = CW'(t); cfgLoc = 4'(l); cfgMode = 2'(mode); cfgHalt = halt; cfgNumVec = CW'(n);
    cmdStart = 1; tick(); cmdStart = 0;
  endtask

  task automatic waitStop();
    for (int k = 0; k < 300; k++) begin
      if (stsDone || stsHold) break;
      tick();
    end
  endtask

  task automatic finishAll();
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  endtask

  initial begin
    #800000;
    nBad++;
    $display("FAIL R14 watchdog actual=running expected=finished");
    finishAll();
  end

  initial begin
    for (int i = 0; i < 64; i++) vmem[i] = {(i % 4 == 0), 8'(i * 3 + 1)};
    @(negedge clk); @(negedge clk);
    mStep();
    // R1 reset state
    chk("R1", 32'({stsDone, stsHold, stsInjected, stsMisSeen}), 0, "flags");
    chk("R1", 32'(stsClass), 0, "class");
    chk("R1", 32'(vecAddr), 0, "vecAddr");
    chk("R1", 32'({refState, faultState}), 0, "states");
    rstN = 1;
    tick(); tick();

    // R7 output mode, accumulator bit
    startRun(3, 2, 1, 0, 10); waitStop();
    chk("R7", 32'(stsClass), 1, "output class");
    chk("R10", 32'(stsFirstMis), 3, "first mismatch");
    chk("R7", 32'(vecAddr), 3, "stop address");

    // R8 latent mode, hold bit not overwritten (vectors 5,6 do not load)
    startRun(5, 12, 2, 0, 7); waitStop();
    chk("R8", 32'(stsClass), 2, "latent class");
    chk("R8", 32'(stsMisSeen), 0, "no output hit");

    // R9 damage mode, hold bit overwritten by vector 4
    startRun(2, 12, 0, 0, 7); waitStop();
    chk("R9", 32'(stsClass), 0, "masked class");

    // R9 damage mode, accumulator bit persists
    startRun(1, 0, 0, 0, 6); waitStop();
    chk("R9", 32'(stsClass), 3, "damage class");
    chk("R10", 32'(stsFirstMis), 1, "first mismatch");

    // R8 latent mode with output hit runs to the end
    startRun(0, 7, 2, 0, 5); waitStop();
    chk("R8", 32'(stsClass), 1, "output in latent mode");
    chk("R8", 32'(vecAddr), 5, "full run");
    tick(); tick();
    chk("R14", 32'({stsDone, stsClass}), 32'({1'b1, 2'd1}), "done held");

    // R11 halt, flip by step, single step; R2 start while parked; R12 resume
    startRun(4, 1, 0, 1, 8); waitStop();
    chk("R11", 32'(stsHold), 1, "parked");
    chk("R11", 32'(vecAddr), 4, "parked address");
    chk("R11", 32'(stsInjected), 0, "not yet flipped");
    cmdStep = 1; tick(); cmdStep = 0;
    chk("R6", 32'(diffState), 32'h0002, "diff after flip");
    chk("R6", 32'(diffCount), 1, "popcount");
    cmdStep = 1; tick(); cmdStep = 0;
    chk("R11", 32'(vecAddr), 5, "one step");
    tick();
    chk("R11", 32'(vecAddr), 5, "frozen");
    cfgLoc = 4'd12; cmdStart = 1; tick(); cmdStart = 0;
    chk("R2", 32'({stsHold, vecAddr}), 32'({1'b1, 10'd5}), "start ignored in hold");
    cmdResume = 1; tick(); cmdResume = 0;
    waitStop();
    chk("R12", 32'(stsClass), 3, "resumed to damage");
    chk("R12", 32'(vecAddr), 8, "resumed to end");

    // R12 resume before flip performs the flip
    startRun(2, 3, 1, 1, 9); waitStop();
    cmdResume = 1; tick(); cmdResume = 0;
    waitStop();
    chk("R12", 32'(stsClass), 1, "resume then flip");
    chk("R12", 32'(stsFirstMis), 2, "first mismatch at T");

    // R13 injection cycle beyond the stream
    startRun(20, 0, 1, 0, 6); waitStop();
    chk("R13", 32'(stsClass), 1, "class");
    chk("R13", 32'(stsFirstMis), 6, "flip after last vector");
    chk("R13", 32'(vecAddr), 6, "address");

    // R2 start mid-run ignored
    startRun(2, 12, 1, 0, 40);
    for (int k = 0; k < 10; k++) tick();
    cfgInjCycle = '0; cfgLoc = 4'd0; cmdStart = 1; tick(); cmdStart = 0;
    waitStop();
    chk("R2", 32'(stsClass), 0, "mid-run start ignored");
    chk("R2", 32'(vecAddr), 40, "first run completes");

    finishAll();
  end

endmodule